// File: doc/BRIEF.md
# Receive Frame Length Classifier

This block sits beside a receive datapath and watches each incoming Ethernet frame as it streams past, one byte per accepted cycle. A frame is delimited by a start marker on its first byte and an end marker on its last byte. A byte counts only in a cycle where the valid strobe is high. The block counts every byte, including the four-byte frame check sequence. It picks the Length/Type field out of the header and, once the last byte has arrived, produces a set of classification flags together with the final byte count.

The flags say four things. The frame is oversized for the current mode (giant). The frame carries an Ethernet type code rather than a payload length. A length-coded frame disagrees with the length it declares. The frame is shorter than the minimum Ethernet size (runt). The oversize limit depends on three inputs: a VLAN-tagged flag, a 2K-frame enable and a jumbo enable. Downstream logic samples the flags on a one-cycle status strobe and may also read them later, because they hold until the next frame ends.

Top module: `rx_len_classifier`

## Requirements
- R1: `st_frame_len` reports the number of accepted bytes in the frame, FCS included, and saturates at 2^CNT_W-1 (16383 by default) instead of wrapping.
- R2: `st_valid` is high for exactly the one cycle after the clock edge that accepted a byte with `in_eof` high. All other status outputs change only at that edge and otherwise hold their values.
- R3: With jumbo and 2K disabled, `st_giant` is set when the length exceeds 1518 bytes for an untagged frame, or 1522 bytes when `in_vlan` is high.
- R4: With jumbo disabled and `cfg_2k_en` high, the giant limit is 2000 bytes, whether or not the frame is tagged.
- R5: With `cfg_jumbo_en` high, the giant limit is 9018 bytes untagged and 9022 bytes tagged, whatever the value of `cfg_2k_en`.
- R6: The Length/Type field is taken big-endian from byte indices 12 (high) and 13 (low), counting the first byte as index 0, or from 16 and 17 when `in_vlan` is high. `st_ethtype` is set when the field is 0x0600 or above.
- R7: `st_type_valid` is set only when both field bytes arrived: at least 14 bytes untagged, or 18 tagged. When it is clear, `st_ethtype` and `st_len_err` are both 0.
- R8: For a length-coded frame (`st_type_valid` high, `st_ethtype` low), `st_len_err` is set when the field differs from the payload size. Payload size is the length minus 18 bytes (untagged) or 22 bytes (tagged). A frame shorter than that overhead is an error. There is one exception: a frame of exactly 64 bytes whose field is below its payload size is padding and is not an error.
- R9: `st_runt` is set when the frame length is below 64 bytes.
- R10: A byte with `in_sof` high restarts the count and discards any captured field, even if the previous frame never ended. Cycles with `in_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_sof | input | 1 | Accepted byte is the first of a frame |
| in_eof | input | 1 | Accepted byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_vlan | input | 1 | Frame carries a VLAN tag; held for the whole frame |
| cfg_2k_en | input | 1 | Raise the giant limit to 2000 bytes |
| cfg_jumbo_en | input | 1 | Jumbo limits; overrides the 2K enable |
| st_valid | output | 1 | One-cycle strobe: status below is new |
| st_frame_len | output | CNT_W | Saturated byte count of the last frame |
| st_giant | output | 1 | Frame longer than the active limit |
| st_ethtype | output | 1 | Length/Type field holds a type code |
| st_type_valid | output | 1 | Length/Type field was fully received |
| st_len_err | output | 1 | Length-coded frame mismatches its field |
| st_runt | output | 1 | Frame shorter than 64 bytes |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, the 1518/1522, 2000 and 9018/9022 limits, and a 64-byte minimum frame. With these values every giant limit can be hit at exactly its threshold and one byte past it. A 16500-byte frame drives the counter into saturation within the run. The small frames are chosen around the 14- and 18-byte header edges and the 64-byte padding rule, so that the field-capture and length-check corners all appear.

// File: rtl/rxlc_pkg.sv
// Shared types for the receive frame length classifier.
// Assumes nothing beyond a synthesizable packed struct.
package rxlc_pkg;

    // Classification flags reported at end of frame.
    typedef struct packed {
        logic giant;
        logic ethtype;
        logic type_valid;
        logic len_err;
        logic runt;
    } rxlc_flags_t;

endpackage

// File: rtl/rxlc_byte_counter.sv
// Saturating byte counter for one frame.
// Gives the index of the byte on the bus this cycle and the count that
// includes it. A start marker forces the index back to zero.
// Assumes the start marker is only meaningful together with in_valid.
module rxlc_byte_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] cnt_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Index of the current byte and the saturated count after it.
    always_comb begin
        idx      = in_sof ? '0 : cnt_q;
        cnt_next = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
    end

    // Advance the count on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/rxlc_lt_capture.sv
// Captures the two-byte Length/Type field, big-endian.
// The field position moves by the tag length when the frame is tagged.
// The next-state value is exported so that a field whose low byte is the
// last byte of the frame is still seen at end of frame.
// Assumes in_vlan is stable from the first byte of the frame onward.
module rxlc_lt_capture #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned LT_POS  = 12,
    parameter int unsigned TAG_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_vlan,
    input  logic [7:0]       in_data,
    input  logic [CNT_W-1:0] idx,
    output logic [15:0]      lt_next,
    output logic             lt_ok_next
);
    localparam logic [CNT_W-1:0] POS_PLAIN  = CNT_W'(LT_POS);
    localparam logic [CNT_W-1:0] POS_TAGGED = CNT_W'(LT_POS + TAG_LEN);

    logic [7:0]       hi_q, lo_q, hi_n, lo_n;
    logic             hi_ok_q, lo_ok_q, hi_ok_n, lo_ok_n;
    logic [CNT_W-1:0] hi_pos;

    // Select the field position for this frame.
    assign hi_pos = in_vlan ? POS_TAGGED : POS_PLAIN;

    // Next-state capture of the high and low field bytes.
    always_comb begin
        hi_n    = hi_q;
        lo_n    = lo_q;
        hi_ok_n = hi_ok_q;
        lo_ok_n = lo_ok_q;
        if (in_valid) begin
            if (in_sof) begin
                hi_ok_n = 1'b0;
                lo_ok_n = 1'b0;
            end
            if (idx == hi_pos) begin
                hi_n    = in_data;
                hi_ok_n = 1'b1;
            end
            if (idx == hi_pos + 1'b1) begin
                lo_n    = in_data;
                lo_ok_n = 1'b1;
            end
        end
    end

    // Hold the captured bytes and their presence bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            hi_ok_q <= 1'b0;
            lo_ok_q <= 1'b0;
        end else begin
            hi_q    <= hi_n;
            lo_q    <= lo_n;
            hi_ok_q <= hi_ok_n;
            lo_ok_q <= lo_ok_n;
        end
    end

    assign lt_next    = {hi_n, lo_n};
    assign lt_ok_next = hi_ok_n && lo_ok_n;

endmodule

// File: rtl/rxlc_size_check.sv
// Combinational classification of a finished frame.
// Works from its length, the captured Length/Type field, the tag flag and
// the two size-mode enables. Jumbo mode takes priority over the 2K mode.
// Assumes the length is already saturated and fits in 32 bits.
module rxlc_size_check
    import rxlc_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned STD_MAX   = 1518,
    parameter int unsigned MAX_2K    = 2000,
    parameter int unsigned JUMBO_MAX = 9018,
    parameter int unsigned TAG_LEN   = 4,
    parameter int unsigned MIN_FRAME = 64,
    parameter int unsigned LT_POS    = 12,
    parameter int unsigned FCS_LEN   = 4,
    parameter int unsigned ETYPE_MIN = 16'h0600
) (
    input  logic [CNT_W-1:0] frame_len,
    input  logic [15:0]      lt,
    input  logic             lt_ok,
    input  logic             vlan,
    input  logic             en_2k,
    input  logic             en_jumbo,
    output rxlc_flags_t      flags
);
    localparam int unsigned HDR_LEN   = LT_POS + 2;
    localparam logic [31:0] OVH_PLAIN = 32'(HDR_LEN + FCS_LEN);
    localparam logic [31:0] OVH_TAG   = 32'(HDR_LEN + TAG_LEN + FCS_LEN);

    logic [31:0] len32, lt32, limit, overhead, payload;
    logic        is_eth;

    // Pick the oversize limit for the active mode.
    always_comb begin
        if (en_jumbo) begin
            limit = vlan ? 32'(JUMBO_MAX + TAG_LEN) : 32'(JUMBO_MAX);
        end else if (en_2k) begin
            limit = 32'(MAX_2K);
        end else begin
            limit = vlan ? 32'(STD_MAX + TAG_LEN) : 32'(STD_MAX);
        end
    end

    // Frame type, payload size and the resulting flags.
    always_comb begin
        len32    = 32'(frame_len);
        lt32     = {16'h0000, lt};
        overhead = vlan ? OVH_TAG : OVH_PLAIN;
        payload  = (len32 >= overhead) ? len32 - overhead : 32'd0;
        is_eth   = lt_ok && (lt32 >= 32'(ETYPE_MIN));

        flags.giant      = len32 > limit;
        flags.runt       = len32 < 32'(MIN_FRAME);
        flags.type_valid = lt_ok;
        flags.ethtype    = is_eth;
        flags.len_err    = 1'b0;
        if (lt_ok && !is_eth) begin
            if (len32 < overhead) begin
                flags.len_err = 1'b1;
            end else begin
                flags.len_err = (lt32 != payload)
                             && !((len32 == 32'(MIN_FRAME)) && (lt32 < payload));
            end
        end
    end

endmodule

// File: rtl/rx_len_classifier.sv
// Receive frame length classifier, top level.
// Counts the bytes of each frame, captures its Length/Type field and, on
// the edge that accepts the last byte, registers the classification flags.
// It then pulses st_valid for one cycle. The flags hold until the next
// frame ends.
// Assumes in_vlan and the two enables are stable from the first byte to the
// last byte of a frame.
module rx_len_classifier
    import rxlc_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned STD_MAX   = 1518,
    parameter int unsigned MAX_2K    = 2000,
    parameter int unsigned JUMBO_MAX = 9018,
    parameter int unsigned TAG_LEN   = 4,
    parameter int unsigned MIN_FRAME = 64,
    parameter int unsigned LT_POS    = 12,
    parameter int unsigned FCS_LEN   = 4,
    parameter int unsigned ETYPE_MIN = 16'h0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             in_vlan,
    input  logic             cfg_2k_en,
    input  logic             cfg_jumbo_en,
    output logic             st_valid,
    output logic [CNT_W-1:0] st_frame_len,
    output logic             st_giant,
    output logic             st_ethtype,
    output logic             st_type_valid,
    output logic             st_len_err,
    output logic             st_runt
);
    logic [CNT_W-1:0] idx, cnt_next;
    logic [15:0]      lt_next;
    logic             lt_ok_next;
    logic             frame_end;
    rxlc_flags_t      flags_c, flags_q;

    assign frame_end = in_valid && in_eof;

    rxlc_byte_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .idx      (idx),
        .cnt_next (cnt_next)
    );

    rxlc_lt_capture #(
        .CNT_W   (CNT_W),
        .LT_POS  (LT_POS),
        .TAG_LEN (TAG_LEN)
    ) u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_vlan    (in_vlan),
        .in_data    (in_data),
        .idx        (idx),
        .lt_next    (lt_next),
        .lt_ok_next (lt_ok_next)
    );

    rxlc_size_check #(
        .CNT_W     (CNT_W),
        .STD_MAX   (STD_MAX),
        .MAX_2K    (MAX_2K),
        .JUMBO_MAX (JUMBO_MAX),
        .TAG_LEN   (TAG_LEN),
        .MIN_FRAME (MIN_FRAME),
        .LT_POS    (LT_POS),
        .FCS_LEN   (FCS_LEN),
        .ETYPE_MIN (ETYPE_MIN)
    ) u_class (
        .frame_len (cnt_next),
        .lt        (lt_next),
        .lt_ok     (lt_ok_next),
        .vlan      (in_vlan),
        .en_2k     (cfg_2k_en),
        .en_jumbo  (cfg_jumbo_en),
        .flags     (flags_c)
    );

    // Register the status on end of frame and raise the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid     <= 1'b0;
            st_frame_len <= '0;
            flags_q      <= '0;
        end else begin
            st_valid <= frame_end;
            if (frame_end) begin
                st_frame_len <= cnt_next;
                flags_q      <= flags_c;
            end
        end
    end

    assign st_giant      = flags_q.giant;
    assign st_ethtype    = flags_q.ethtype;
    assign st_type_valid = flags_q.type_valid;
    assign st_len_err    = flags_q.len_err;
    assign st_runt       = flags_q.runt;

endmodule

// File: rtl/rxlc_checker.sv
// Property checker for rx_len_classifier, attached by bind.
// Relates the status outputs to the input stream and to each other.
module rxlc_checker #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned STD_MAX   = 1518,
    parameter int unsigned MIN_FRAME = 64,
    parameter int unsigned LT_POS    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             st_valid,
    input logic [CNT_W-1:0] st_frame_len,
    input logic             st_giant,
    input logic             st_ethtype,
    input logic             st_type_valid,
    input logic             st_len_err,
    input logic             st_runt
);
    // R2: strobe follows each accepted last byte by one cycle.
    assert_strobe_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_valid == $past(in_valid && in_eof)));

    // R2: without a strobe the reported status does not move.
    assert_status_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !st_valid) |-> ($stable(st_frame_len) && $stable(st_giant)
                                         && $stable(st_len_err) && $stable(st_ethtype)));

    // R7: a type code needs a fully received field.
    assert_type_needs_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_ethtype |-> st_type_valid);

    // R7: the field cannot be present in a frame shorter than its end.
    assert_field_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_type_valid |-> (32'(st_frame_len) >= 32'(LT_POS + 2)));

    // R8: length errors only on length-coded frames.
    assert_lenerr_8023_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_len_err |-> (st_type_valid && !st_ethtype));

    // R3: no mode has a giant limit below the standard one.
    assert_giant_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_giant |-> (32'(st_frame_len) > 32'(STD_MAX)));

    // R9: a runt frame is never also giant.
    assert_runt_not_giant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_runt |-> (!st_giant && (32'(st_frame_len) < 32'(MIN_FRAME))));

endmodule

bind rx_len_classifier rxlc_checker #(
    .CNT_W     (CNT_W),
    .STD_MAX   (STD_MAX),
    .MIN_FRAME (MIN_FRAME),
    .LT_POS    (LT_POS)
) u_rxlc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_eof        (in_eof),
    .st_valid      (st_valid),
    .st_frame_len  (st_frame_len),
    .st_giant      (st_giant),
    .st_ethtype    (st_ethtype),
    .st_type_valid (st_type_valid),
    .st_len_err    (st_len_err),
    .st_runt       (st_runt)
);

// File: tb/test_rx_len_classifier.sv
`timescale 1ns/1ps
module test_rx_len_classifier;

    localparam int CNT_W = 14;

    typedef struct packed {
        logic [31:0] len;
        logic [15:0] lt;
        logic        vlan;
        logic        c2k;
        logic        cjm;
        logic        giant;
        logic        eth;
        logic        tv;
        logic        lerr;
        logic        runt;
    } vec_t;

    localparam int NV = 21;
    // len, field, vlan, 2k, jumbo | giant, eth, type_valid, len_err, runt
    localparam vec_t VECS [NV] = '{
        '{32'd64,   16'h0800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
        '{32'd1518, 16'h0800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
        '{32'd1519, 16'h0800, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
        '{32'd1522, 16'h0800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
        '{32'd1523, 16'h0800, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
        '{32'd2000, 16'h0800, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{32'd2001, 16'h0800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{32'd1600, 16'h0600, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{32'd9018, 16'h0800, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{32'd9019, 16'h0800, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{32'd9022, 16'h0800, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{32'd9023, 16'h0800, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
        '{32'd100,  16'd82,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{32'd100,  16'd83,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8
        '{32'd100,  16'd78,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{32'd64,   16'd10,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{32'd64,   16'd47,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8
        '{32'd40,   16'd22,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R9
        '{32'd13,   16'h0800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
        '{32'd17,   16'h0800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
        '{32'd14,   16'h05FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}  // R8
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_vlan = 1'b0, cfg_2k_en = 1'b0, cfg_jumbo_en = 1'b0;
    logic             st_valid, st_giant, st_ethtype, st_type_valid, st_len_err, st_runt;
    logic [CNT_W-1:0] st_frame_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_len_classifier #(.CNT_W(CNT_W)) i_rx_len_classifier (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_data       (in_data),
        .in_vlan       (in_vlan),
        .cfg_2k_en     (cfg_2k_en),
        .cfg_jumbo_en  (cfg_jumbo_en),
        .st_valid      (st_valid),
        .st_frame_len  (st_frame_len),
        .st_giant      (st_giant),
        .st_ethtype    (st_ethtype),
        .st_type_valid (st_type_valid),
        .st_len_err    (st_len_err),
        .st_runt       (st_runt)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one frame; returns on the negedge after the edge taking the last byte.
    task automatic send_frame(input int len, input logic [15:0] lt, input logic vlan,
                              input logic gaps, input logic with_eof);
        int hp = vlan ? 16 : 12;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 7) == 3) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hEE;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = with_eof && (i == len - 1);
            if (i == hp)          in_data = lt[15:8];
            else if (i == hp + 1) in_data = lt[7:0];
            else                  in_data = 8'(i) ^ 8'h5A;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [CNT_W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2)
        chk("R2", "reset st_valid", st_valid, 0);
        chk("R1", "reset frame_len", st_frame_len, 0);
        chk("R3", "reset giant", st_giant, 0);
        chk("R7", "reset type_valid", st_type_valid, 0);

        // Table walk (R1, R3..R9); gaps on odd entries exercise R10
        for (int v = 0; v < NV; v++) begin
            in_vlan      = VECS[v].vlan;
            cfg_2k_en    = VECS[v].c2k;
            cfg_jumbo_en = VECS[v].cjm;
            send_frame(int'(VECS[v].len), VECS[v].lt, VECS[v].vlan, v[0], 1'b1);
            chk("R2", $sformatf("vec%0d strobe", v), st_valid, 1);
            chk("R1", $sformatf("vec%0d frame_len", v), st_frame_len, VECS[v].len);
            chk("R3", $sformatf("vec%0d giant", v), st_giant, VECS[v].giant);
            chk("R6", $sformatf("vec%0d ethtype", v), st_ethtype, VECS[v].eth);
            chk("R7", $sformatf("vec%0d type_valid", v), st_type_valid, VECS[v].tv);
            chk("R8", $sformatf("vec%0d len_err", v), st_len_err, VECS[v].lerr);
            chk("R9", $sformatf("vec%0d runt", v), st_runt, VECS[v].runt);
            @(negedge clk);
            chk("R2", $sformatf("vec%0d strobe low", v), st_valid, 0);
            chk("R2", $sformatf("vec%0d len held", v), st_frame_len, VECS[v].len);
        end

        // R10: aborted frame with a field, restarted by a 13-byte frame
        in_vlan = 1'b0; cfg_2k_en = 1'b0; cfg_jumbo_en = 1'b0;
        send_frame(30, 16'h0500, 1'b0, 1'b0, 1'b0);
        chk("R10", "no strobe without eof", st_valid, 0);
        send_frame(13, 16'h0800, 1'b0, 1'b1, 1'b1);
        chk("R10", "restart frame_len", st_frame_len, 13);
        chk("R10", "restart drops old field", st_type_valid, 0);
        chk("R10", "restart ethtype", st_ethtype, 0);

        // R1: saturation at 16383 with jumbo on
        cfg_jumbo_en = 1'b1;
        send_frame(16500, 16'h0800, 1'b0, 1'b0, 1'b1);
        chk("R1", "saturated frame_len", st_frame_len, 16383);
        chk("R5", "saturated giant", st_giant, 1);
        chk("R6", "saturated ethtype", st_ethtype, 1);

        // R2: status holds across idle cycles
        held = st_frame_len;
        repeat (5) @(negedge clk);
        chk("R2", "idle hold", st_frame_len, held);
        chk("R2", "idle strobe", st_valid, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule